// File: doc/BRIEF.md
# Float to Integer Converter

This block turns an IEEE-754 single-precision operand into a signed 32-bit integer. The rounding direction is chosen for each operation by a 2-bit input. Each conversion reports four exception flags: invalid operation, integer too large, inexact and subnormal operand. Three more flag outputs (divide-by-zero, overflow, underflow) are present so the block fits a common exception vector, and they never assert. A mode input makes subnormal operands count as zero.

The datapath is a fixed-latency pipeline that accepts one operand per cycle. A classify stage decodes the operand. An align-and-round stage produces the rounded magnitude. A pack stage applies the sign, saturates, and selects the special values. The `PIPE_MID` parameter sets whether the middle stage is registered, so the latency is two or three cycles (three by default).

Operands that round outside the 32-bit signed range saturate to the extreme integer of the operand's sign and raise both the too-large and the invalid flags. Infinities and NaNs return the integer indefinite value 0x8000_0000 with only the invalid flag set.

Top module: `f2i_conv`

## Requirements
- R1: Every cycle with `i_valid` high produces exactly one `o_done` pulse 2+`PIPE_MID` cycles later (3 by default). Results come out in input order, and back-to-back operands are accepted.
- R2: A finite operand whose rounded value fits in [-2^31, 2^31-1] returns that rounded integer. `i_rmode` selects the rounding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: For an in-range finite result, `o_inexact` is 1 exactly when the operand had a nonzero fraction that rounding discarded.
- R4: When the rounded value is outside [-2^31, 2^31-1], `o_too_large` is 1 and `o_inexact` is 0. The result is 0x7FFF_FFFF for a positive operand and 0x8000_0000 for a negative one. An operand of exactly -2^31 is in range and raises no flag.
- R5: Whenever `o_too_large` is 1, `o_invalid` is also 1.
- R6: An operand with an all-ones exponent (infinity, quiet NaN or signaling NaN) returns 0x8000_0000 with `o_invalid` = 1 and `o_too_large` = `o_inexact` = 0.
- R7: With `i_saz` = 0, a subnormal operand sets `o_subop` and `o_inexact`. The result is the tiny value rounded as usual: 0, or +1 for a positive operand rounded toward +infinity, or -1 for a negative operand rounded toward -infinity.
- R8: With `i_saz` = 1, a subnormal operand is handled as zero: result 0 and every flag 0. Normal operands are converted exactly as with `i_saz` = 0.
- R9: `o_div0`, `o_ovf` and `o_udf` are 0 for every conversion.
- R10: A zero operand of either sign returns 0 with every flag 0.
- R11: After reset, `o_done`, `o_result` and all flags are 0 until the first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Operand strobe |
| i_fp | input | 32 | Single-precision operand |
| i_rmode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| i_saz | input | 1 | Treat subnormal operands as zero |
| o_done | output | 1 | Result strobe |
| o_result | output | 32 | Signed integer result |
| o_invalid | output | 1 | Invalid operation flag |
| o_too_large | output | 1 | Integer too large flag |
| o_inexact | output | 1 | Inexact flag |
| o_subop | output | 1 | Subnormal operand flag |
| o_div0 | output | 1 | Divide-by-zero flag, always 0 |
| o_ovf | output | 1 | Overflow flag, always 0 |
| o_udf | output | 1 | Underflow flag, always 0 |

## Verification
A wrong decode in the classify stage shows up at the ports on the very result that carries it, 2+`PIPE_MID` cycles after the operand. Typical symptoms are an indefinite value where a saturated one belongs, or a subnormal flag raised while subnormals count as zero. Faults in round-bit or sticky-bit extraction are only visible on operands with a fraction, so the vectors pair each rounding mode with exact ties, near-ties and negative values. Range faults sit at the ends of the integer range, so the vectors include -2^31, 2^31 and the largest float below 2^31. The streamed, back-to-back vectors would expose a stage register that drops or repeats an operand, because every later result would then be paired with the wrong expected value.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_TO_POS    = 2'd2,
      RM_TO_NEG    = 2'd3
   } rmode_e;

   typedef enum logic [1:0] {
      OPK_ZERO    = 2'd0,
      OPK_FINITE  = 2'd1,
      OPK_SPECIAL = 2'd2
   } opkind_e;

   // Decide whether the truncated magnitude must be incremented.
   function automatic logic round_incr(input rmode_e mode, input logic neg,
                                       input logic lsb, input logic rbit,
                                       input logic sticky);
      logic inc;
      unique case (mode)
         RM_NEAR_EVEN: inc = rbit & (sticky | lsb);
         RM_TO_ZERO:   inc = 1'b0;
         RM_TO_POS:    inc = ~neg & (rbit | sticky);
         default:      inc = neg & (rbit | sticky);
      endcase
      return inc;
   endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
   import f2i_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FP_W  = EXP_W + MAN_W + 1,
   localparam int ES_W  = EXP_W + 2
) (
   input  logic                   i_saz,
   input  logic [FP_W-1:0]        i_fp,
   output logic                   o_sign,
   output opkind_e                o_kind,
   output logic                   o_subop,
   output logic signed [ES_W-1:0] o_exp,
   output logic [MAN_W:0]         o_mant
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [ES_W-1:0] BIAS_V   = ES_W'(BIAS);
   localparam logic [ES_W-1:0] SUBEXP_V = ES_W'(1 - BIAS);

   generate
      if (EXP_W < 4 || MAN_W < 4) begin : g_bad_fmt
         $error("f2i_classify: exponent and mantissa need at least 4 bits");
      end
   endgenerate

   logic [EXP_W-1:0] exp_field;
   logic [MAN_W-1:0] frac_field;
   logic             exp_max;
   logic             exp_min;
   logic             frac_nz;

   assign exp_field  = i_fp[MAN_W +: EXP_W];
   assign frac_field = i_fp[MAN_W-1:0];
   assign exp_max    = &exp_field;
   assign exp_min    = ~|exp_field;
   assign frac_nz    = |frac_field;
   assign o_sign     = i_fp[FP_W-1];

   always_comb begin
      o_kind  = OPK_ZERO;
      o_subop = 1'b0;
      o_exp   = '0;
      o_mant  = '0;
      if (exp_max) begin
         o_kind = OPK_SPECIAL;
      end else if (exp_min) begin
         if (frac_nz && !i_saz) begin
            o_kind  = OPK_FINITE;
            o_subop = 1'b1;
            o_exp   = signed'(SUBEXP_V);
            o_mant  = {1'b0, frac_field};
         end
      end else begin
         o_kind = OPK_FINITE;
         o_exp  = signed'({2'b00, exp_field} - BIAS_V);
         o_mant = {1'b1, frac_field};
      end
   end

endmodule

// File: rtl/f2i_align_round.sv
module f2i_align_round
   import f2i_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32,
   localparam int ES_W  = EXP_W + 2,
   localparam int MG_W  = INT_W + 1,
   localparam int KEEP  = MAN_W + 2,
   localparam int EXT_W = MAN_W + 1 + KEEP,
   localparam int RS_W  = $clog2(KEEP + 1),
   localparam int LS_W  = $clog2(INT_W)
) (
   input  opkind_e                i_kind,
   input  logic                   i_sign,
   input  logic signed [ES_W-1:0] i_exp,
   input  logic [MAN_W:0]         i_mant,
   input  rmode_e                 i_rmode,
   output logic [MG_W-1:0]        o_mag,
   output logic                   o_inexact,
   output logic                   o_big
);

   localparam logic signed [ES_W-1:0] EXP_BIG   = ES_W'(INT_W);
   localparam logic signed [ES_W-1:0] EXP_EXACT = ES_W'(MAN_W);
   localparam logic signed [ES_W-1:0] KEEP_S    = ES_W'(KEEP);

   generate
      if (INT_W <= MAN_W + 1) begin : g_bad_int
         $error("f2i_align_round: integer must be wider than the significand");
      end
      if (INT_W >= (1 << (EXP_W - 1))) begin : g_bad_range
         $error("f2i_align_round: integer width exceeds exponent range");
      end
   endgenerate

   logic signed [ES_W-1:0] rdist;
   logic signed [ES_W-1:0] ldist;
   logic [RS_W-1:0]        rsh;
   logic [LS_W-1:0]        lsh;
   logic [EXT_W-1:0]       ext;
   logic [MAN_W:0]         ipart;
   logic                   rbit;
   logic                   sticky;
   logic                   inc;

   assign rdist = EXP_EXACT - i_exp;
   assign ldist = i_exp - EXP_EXACT;
   assign rsh   = (rdist > KEEP_S) ? RS_W'(KEEP) : rdist[RS_W-1:0];
   assign lsh   = ldist[LS_W-1:0];

   assign ext    = {i_mant, {KEEP{1'b0}}} >> rsh;
   assign ipart  = ext[EXT_W-1 -: MAN_W + 1];
   assign rbit   = ext[KEEP-1];
   assign sticky = |ext[KEEP-2:0];
   assign inc    = round_incr(i_rmode, i_sign, ipart[0], rbit, sticky);

   always_comb begin
      o_mag     = '0;
      o_inexact = 1'b0;
      o_big     = 1'b0;
      if (i_kind == OPK_FINITE) begin
         if (i_exp >= EXP_BIG) begin
            o_big = 1'b1;
         end else if (i_exp >= EXP_EXACT) begin
            o_mag = MG_W'(i_mant) << lsh;
         end else begin
            o_mag     = MG_W'(ipart) + MG_W'(inc);
            o_inexact = rbit | sticky;
         end
      end
   end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
   import f2i_pkg::*;
#(
   parameter int INT_W = 32,
   localparam int MG_W = INT_W + 1
) (
   input  opkind_e           i_kind,
   input  logic              i_sign,
   input  logic [MG_W-1:0]   i_mag,
   input  logic              i_big,
   input  logic              i_inexact,
   input  logic              i_subop,
   output logic [INT_W-1:0]  o_result,
   output logic              o_invalid,
   output logic              o_too_large,
   output logic              o_inexact,
   output logic              o_subop
);

   localparam logic [MG_W-1:0]  POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
   localparam logic [MG_W-1:0]  NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] INDEF   = INT_MIN;

   generate
      if (INT_W < 8) begin : g_bad_w
         $error("f2i_pack: integer width too small");
      end
   endgenerate

   logic out_of_range;
   logic [INT_W-1:0] mag_lo;

   assign mag_lo       = i_mag[INT_W-1:0];
   assign out_of_range = i_big | (i_sign ? (i_mag > NEG_LIM) : (i_mag > POS_LIM));
   assign o_subop      = i_subop;

   always_comb begin
      o_result    = '0;
      o_invalid   = 1'b0;
      o_too_large = 1'b0;
      o_inexact   = 1'b0;
      unique case (i_kind)
         OPK_SPECIAL: begin
            o_result  = INDEF;
            o_invalid = 1'b1;
         end
         OPK_FINITE: begin
            if (out_of_range) begin
               o_result    = i_sign ? INT_MIN : INT_MAX;
               o_invalid   = 1'b1;
               o_too_large = 1'b1;
            end else begin
               o_result  = i_sign ? (~mag_lo + 1'b1) : mag_lo;
               o_inexact = i_inexact;
            end
         end
         default: o_result = '0;
      endcase
   end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
   import f2i_pkg::*;
#(
   parameter int EXP_W    = 8,
   parameter int MAN_W    = 23,
   parameter int INT_W    = 32,
   parameter bit PIPE_MID = 1'b1,
   localparam int FP_W    = EXP_W + MAN_W + 1,
   localparam int ES_W    = EXP_W + 2,
   localparam int MG_W    = INT_W + 1,
   localparam int LAT     = 2 + int'(PIPE_MID)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_valid,
   input  logic [FP_W-1:0]  i_fp,
   input  logic [1:0]       i_rmode,
   input  logic             i_saz,
   output logic             o_done,
   output logic [INT_W-1:0] o_result,
   output logic             o_invalid,
   output logic             o_too_large,
   output logic             o_inexact,
   output logic             o_subop,
   output logic             o_div0,
   output logic             o_ovf,
   output logic             o_udf
);

   localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

   // ---------------- stage 1: decode ----------------
   logic                   c_sign, c_subop;
   opkind_e                c_kind;
   logic signed [ES_W-1:0] c_exp;
   logic [MAN_W:0]         c_mant;

   f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
      .i_saz   (i_saz),
      .i_fp    (i_fp),
      .o_sign  (c_sign),
      .o_kind  (c_kind),
      .o_subop (c_subop),
      .o_exp   (c_exp),
      .o_mant  (c_mant)
   );

   logic                   s1_v, s1_sign, s1_subop;
   opkind_e                s1_kind;
   logic signed [ES_W-1:0] s1_exp;
   logic [MAN_W:0]         s1_mant;
   rmode_e                 s1_rm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s1_sign  <= 1'b0;
         s1_subop <= 1'b0;
         s1_kind  <= OPK_ZERO;
         s1_exp   <= '0;
         s1_mant  <= '0;
         s1_rm    <= RM_NEAR_EVEN;
      end else begin
         s1_v <= i_valid;
         if (i_valid) begin
            s1_sign  <= c_sign;
            s1_subop <= c_subop;
            s1_kind  <= c_kind;
            s1_exp   <= c_exp;
            s1_mant  <= c_mant;
            s1_rm    <= rmode_e'(i_rmode);
         end
      end
   end

   // ---------------- stage 2: align and round ----------------
   logic [MG_W-1:0] a_mag;
   logic            a_inx, a_big;

   f2i_align_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
      .i_kind    (s1_kind),
      .i_sign    (s1_sign),
      .i_exp     (s1_exp),
      .i_mant    (s1_mant),
      .i_rmode   (s1_rm),
      .o_mag     (a_mag),
      .o_inexact (a_inx),
      .o_big     (a_big)
   );

   logic            s2_v, s2_sign, s2_subop, s2_inx, s2_big;
   opkind_e         s2_kind;
   logic [MG_W-1:0] s2_mag;

   generate
      if (PIPE_MID) begin : g_mid_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_v     <= 1'b0;
               s2_sign  <= 1'b0;
               s2_subop <= 1'b0;
               s2_inx   <= 1'b0;
               s2_big   <= 1'b0;
               s2_kind  <= OPK_ZERO;
               s2_mag   <= '0;
            end else begin
               s2_v <= s1_v;
               if (s1_v) begin
                  s2_sign  <= s1_sign;
                  s2_subop <= s1_subop;
                  s2_inx   <= a_inx;
                  s2_big   <= a_big;
                  s2_kind  <= s1_kind;
                  s2_mag   <= a_mag;
               end
            end
         end
      end else begin : g_mid_wire
         assign s2_v     = s1_v;
         assign s2_sign  = s1_sign;
         assign s2_subop = s1_subop;
         assign s2_inx   = a_inx;
         assign s2_big   = a_big;
         assign s2_kind  = s1_kind;
         assign s2_mag   = a_mag;
      end
   endgenerate

   // ---------------- stage 3: sign, saturate, flags ----------------
   logic [INT_W-1:0] p_res;
   logic             p_inv, p_big, p_inx, p_sub;

   f2i_pack #(.INT_W(INT_W)) u_pack (
      .i_kind      (s2_kind),
      .i_sign      (s2_sign),
      .i_mag       (s2_mag),
      .i_big       (s2_big),
      .i_inexact   (s2_inx),
      .i_subop     (s2_subop),
      .o_result    (p_res),
      .o_invalid   (p_inv),
      .o_too_large (p_big),
      .o_inexact   (p_inx),
      .o_subop     (p_sub)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_done      <= 1'b0;
         o_result    <= '0;
         o_invalid   <= 1'b0;
         o_too_large <= 1'b0;
         o_inexact   <= 1'b0;
         o_subop     <= 1'b0;
      end else begin
         o_done <= s2_v;
         if (s2_v) begin
            o_result    <= p_res;
            o_invalid   <= p_inv;
            o_too_large <= p_big;
            o_inexact   <= p_inx;
            o_subop     <= p_sub;
         end
      end
   end

   assign o_div0 = 1'b0;
   assign o_ovf  = 1'b0;
   assign o_udf  = 1'b0;

   // ---------------- assertions ----------------
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      o_done |-> $past(i_valid, LAT)); // R1
   AST_BIG_SETS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      o_done && o_too_large |-> o_invalid); // R5
   AST_BIG_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      o_done && o_too_large |-> (o_result == INT_MAX || o_result == INT_MIN) && !o_inexact); // R4
   AST_SPECIAL_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
      o_done && o_invalid && !o_too_large |-> o_result == INT_MIN && !o_inexact); // R6
   AST_SAZ_NO_SUBOP: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid && i_saz |=> !s1_subop); // R8
   AST_SUBOP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
      o_done && o_subop |-> o_inexact && !o_invalid &&
      (o_result == '0 || o_result == INT_W'(1) || o_result == '1)); // R7

endmodule

// File: tb/f2i_conv_bench.sv
module f2i_conv_bench;

   localparam int CLK_P = 10;
   localparam int LAT   = 3;

   localparam logic [6:0] F_NONE = 7'h00;
   localparam logic [6:0] F_INV  = 7'h01;
   localparam logic [6:0] F_INX  = 7'h10;
   localparam logic [6:0] F_BIG  = 7'h20;
   localparam logic [6:0] F_SUB  = 7'h40;
   localparam logic [1:0] NE = 2'd0, TZ = 2'd1, UP = 2'd2, DN = 2'd3;

   typedef struct {
      logic [31:0] res;
      logic [6:0]  flg;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [31:0] i_fp = '0;
   logic [1:0]  i_rmode = '0;
   logic        i_saz = 1'b0;
   logic        o_done, o_invalid, o_too_large, o_inexact, o_subop;
   logic        o_div0, o_ovf, o_udf;
   logic [31:0] o_result;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   f2i_conv u_f2i_conv (
      .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_fp(i_fp),
      .i_rmode(i_rmode), .i_saz(i_saz), .o_done(o_done), .o_result(o_result),
      .o_invalid(o_invalid), .o_too_large(o_too_large), .o_inexact(o_inexact),
      .o_subop(o_subop), .o_div0(o_div0), .o_ovf(o_ovf), .o_udf(o_udf)
   );

   function automatic logic [6:0] got_flags();
      return {o_subop, o_too_large, o_inexact, o_udf, o_ovf, o_div0, o_invalid};
   endfunction

   task automatic put(input logic [31:0] f, input logic [1:0] rm, input logic saz,
                      input logic [31:0] er, input logic [6:0] ef, input string tag);
      exp_t e;
      @(posedge clk); #1;
      i_valid = 1'b1; i_fp = f; i_rmode = rm; i_saz = saz;
      e.res = er; e.flg = ef; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      i_valid = 1'b0;
   endtask

   // monitor: pop and compare at each completed conversion
   always @(negedge clk) begin
      if (rst_n && o_done && !finished) begin
         n_vec++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R1 unexpected done: actual result %h, expected no result", o_result);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (o_result !== e.res || got_flags() !== e.flg) begin
               n_bad++;
               $display("FAIL %s: actual %h flags %b, expected %h flags %b",
                        e.tag, o_result, got_flags(), e.res, e.flg);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_P * 100000);
      if (!finished) begin
         n_bad++;
         $display("FAIL R1 watchdog expired: actual hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int lat;
      int guard;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      n_vec++;
      if (o_done !== 1'b0 || o_result !== '0 || got_flags() !== F_NONE) begin
         n_bad++;
         $display("FAIL R11 reset: actual done %b result %h flags %b, expected 0 0 0",
                  o_done, o_result, got_flags());
      end
      rst_n = 1'b1;

      // R1 latency of an isolated operand
      put(32'h3F80_0000, NE, 1'b0, 32'h0000_0001, F_NONE, "R1 latency 1.0");
      idle();
      lat = 0;
      guard = 0;
      while (!o_done && guard < 20) begin
         @(negedge clk);
         lat++;
         guard++;
      end
      n_vec++;
      if (lat != LAT) begin
         n_bad++;
         $display("FAIL R1 latency: actual %0d, expected %0d", lat, LAT);
      end
      repeat (4) @(posedge clk);

      // R2/R3 nearest-even, back to back
      put(32'h3FC0_0000, NE, 1'b0, 32'h0000_0002, F_INX, "R2 1.5 nearest");
      put(32'h4020_0000, NE, 1'b0, 32'h0000_0002, F_INX, "R2 2.5 nearest tie even");
      put(32'h4060_0000, NE, 1'b0, 32'h0000_0004, F_INX, "R2 3.5 nearest tie even");
      put(32'hC020_0000, NE, 1'b0, 32'hFFFF_FFFE, F_INX, "R2 -2.5 nearest");
      put(32'h4030_0000, NE, 1'b0, 32'h0000_0003, F_INX, "R2 2.75 nearest");
      put(32'hBFA0_0000, NE, 1'b0, 32'hFFFF_FFFF, F_INX, "R3 -1.25 nearest");
      put(32'h3F40_0000, NE, 1'b0, 32'h0000_0001, F_INX, "R3 0.75 nearest");
      put(32'h3FFF_FFFF, NE, 1'b0, 32'h0000_0002, F_INX, "R2 near-2 nearest");
      put(32'h3FFF_FFFF, TZ, 1'b0, 32'h0000_0001, F_INX, "R2 near-2 toward zero");
      // directed modes
      put(32'h4020_0000, TZ, 1'b0, 32'h0000_0002, F_INX, "R2 2.5 toward zero");
      put(32'h4020_0000, UP, 1'b0, 32'h0000_0003, F_INX, "R2 2.5 toward +inf");
      put(32'h4020_0000, DN, 1'b0, 32'h0000_0002, F_INX, "R2 2.5 toward -inf");
      put(32'hC020_0000, TZ, 1'b0, 32'hFFFF_FFFE, F_INX, "R2 -2.5 toward zero");
      put(32'hC020_0000, UP, 1'b0, 32'hFFFF_FFFE, F_INX, "R2 -2.5 toward +inf");
      put(32'hC020_0000, DN, 1'b0, 32'hFFFF_FFFD, F_INX, "R2 -2.5 toward -inf");
      put(32'h3F00_0000, NE, 1'b0, 32'h0000_0000, F_INX, "R2 0.5 nearest");
      put(32'h3F00_0000, TZ, 1'b0, 32'h0000_0000, F_INX, "R2 0.5 toward zero");
      put(32'h3F00_0000, UP, 1'b0, 32'h0000_0001, F_INX, "R2 0.5 toward +inf");
      put(32'h3F00_0000, DN, 1'b0, 32'h0000_0000, F_INX, "R2 0.5 toward -inf");
      put(32'hBF00_0000, DN, 1'b0, 32'hFFFF_FFFF, F_INX, "R2 -0.5 toward -inf");
      put(32'hBF00_0000, UP, 1'b0, 32'h0000_0000, F_INX, "R2 -0.5 toward +inf");
      // exact large values
      put(32'h4B00_0001, DN, 1'b0, 32'h0080_0001, F_NONE, "R3 exact 2^23+1");
      put(32'h4B7F_FFFF, UP, 1'b0, 32'h00FF_FFFF, F_NONE, "R3 exact 2^24-1");
      put(32'h4E80_0000, NE, 1'b0, 32'h4000_0000, F_NONE, "R2 2^30");
      put(32'h4EFF_FFFF, TZ, 1'b0, 32'h7FFF_FF80, F_NONE, "R2 largest below 2^31");
      put(32'hCF00_0000, NE, 1'b0, 32'h8000_0000, F_NONE, "R4 exactly -2^31 fits");
      put(32'hCF00_0000, DN, 1'b0, 32'h8000_0000, F_NONE, "R4 -2^31 toward -inf");
      // saturation R4/R5, R9 via zero div0/ovf/udf
      put(32'h4F00_0000, NE, 1'b0, 32'h7FFF_FFFF, F_BIG | F_INV, "R4 R5 2^31 saturates");
      put(32'hCF40_0000, UP, 1'b0, 32'h8000_0000, F_BIG | F_INV, "R4 R5 -1.5*2^31");
      put(32'h7EFF_FFFF, DN, 1'b0, 32'h7FFF_FFFF, F_BIG | F_INV, "R9 huge positive");
      put(32'hFEFF_FFFF, NE, 1'b0, 32'h8000_0000, F_BIG | F_INV, "R5 huge negative");
      // specials R6
      put(32'h7F80_0000, NE, 1'b0, 32'h8000_0000, F_INV, "R6 +inf");
      put(32'hFF80_0000, UP, 1'b0, 32'h8000_0000, F_INV, "R6 -inf");
      put(32'h7FC0_0000, TZ, 1'b0, 32'h8000_0000, F_INV, "R6 quiet NaN");
      put(32'h7F80_0001, DN, 1'b0, 32'h8000_0000, F_INV, "R6 signaling NaN");
      put(32'hFFC0_0000, NE, 1'b1, 32'h8000_0000, F_INV, "R6 negative NaN");
      // subnormals R7
      put(32'h0000_0001, NE, 1'b0, 32'h0000_0000, F_SUB | F_INX, "R7 tiny nearest");
      put(32'h0000_0001, UP, 1'b0, 32'h0000_0001, F_SUB | F_INX, "R7 tiny toward +inf");
      put(32'h8000_0001, DN, 1'b0, 32'hFFFF_FFFF, F_SUB | F_INX, "R7 -tiny toward -inf");
      put(32'h807F_FFFF, UP, 1'b0, 32'h0000_0000, F_SUB | F_INX, "R7 -tiny toward +inf");
      // subnormals as zero R8
      put(32'h0000_0001, UP, 1'b1, 32'h0000_0000, F_NONE, "R8 tiny with saz");
      put(32'h807F_FFFF, DN, 1'b1, 32'h0000_0000, F_NONE, "R8 -tiny with saz");
      put(32'h0080_0000, UP, 1'b1, 32'h0000_0001, F_INX, "R8 smallest normal with saz");
      put(32'h4020_0000, NE, 1'b1, 32'h0000_0002, F_INX, "R8 normal with saz");
      // zeros R10
      put(32'h0000_0000, UP, 1'b0, 32'h0000_0000, F_NONE, "R10 +0");
      put(32'h8000_0000, DN, 1'b0, 32'h0000_0000, F_NONE, "R10 -0");
      idle();

      guard = 0;
      while (sb.size() != 0 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      repeat (LAT + 2) @(negedge clk);
      n_vec++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R1 results missing: actual %0d pending, expected 0", sb.size());
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule